// File: doc/BRIEF.md
# Odd/Even Card Clock Divider

This block derives the card bus clock of an SD/MMC host controller from the module bus clock. Software writes a divider code through a simple mode write port. In extended mode the code gives any integer divide ratio from 2 to 513, odd or even. In legacy mode only even ratios are possible. Along with the card clock, the block produces two strobes, each one bus-clock cycle wide. These mark the rising and falling card-clock edges so that the command and data shifters can act on them without a second clock domain.

A new divider setting is staged and taken into use only at the boundary where a low phase ends and a high phase starts. A rewrite while the clock is running therefore never produces a truncated pulse. An enable input stops the clock, held low. Raising enable again restarts it with a fresh high phase.

Some bus-mode changes require a pause of at least eight card clock cycles before the next command. A small hold-off counter supports this: it is armed by a start pulse and raises a ready flag after the required number of rising card-clock edges.

Top module: `card_clk_gen`

## Requirements
- R1: In extended mode (mode bit 24 = 0) the divider code is the mode write data bits [7:0] (upper part, DIV) plus bit 16 (least significant bit, ODD). The card clock stays high for DIV+1+ODD bus cycles and low for DIV+1 bus cycles, for a ratio of 2*DIV+ODD+2. The high phase is never shorter than the low phase and never more than one cycle longer.
- R2: In legacy mode (mode bit 24 = 1) the ODD bit has no effect. The card clock is high for DIV+1 and low for DIV+1 bus cycles, for a ratio of 2*(DIV+1).
- R3: The ratio limits hold at the ends of the range. Extended mode gives a ratio of 2 for code 0 and 513 for code 511 (DIV=255, ODD=1). Legacy mode gives a ratio of 2 for DIV=0 and 512 for DIV=255, with either ODD value.
- R4: After reset the mode holds DIV=255, ODD=1 and extended mode. The card clock and both strobes are low and the hold-off ready flag is 1. The first enable then yields 257 high cycles followed by 256 low cycles.
- R5: A mode write while the clock runs changes nothing in the current high and low phases. The new phase lengths start with the next high phase.
- R6: While enable is low, the card clock is low from the next bus cycle on and both strobes stay 0. When enable goes high again, the card clock goes high at the next bus edge, with a rising strobe, starting a full high phase.
- R7: During enabled operation, the rising strobe is 1 in exactly the bus cycles where the card clock has just gone from 0 to 1. The falling strobe is 1 in exactly the bus cycles where it has just gone from 1 to 0. Each strobe lasts one cycle.
- R8: A hold-off start pulse clears the ready flag in the next cycle. Ready returns to 1 in the cycle after the 8th rising strobe that follows the start cycle. A rising strobe in the start cycle itself is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the card clock when high |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 32 | Mode word: [7:0] DIV, [16] ODD, [24] legacy select |
| hold_start | input | 1 | Arms the post-switch hold-off counter |
| card_clk | output | 1 | Divided card bus clock |
| rise_stb | output | 1 | One-cycle strobe marking a card clock rising edge |
| fall_stb | output | 1 | One-cycle strobe marking a card clock falling edge |
| hold_ready | output | 1 | High once the hold-off interval has elapsed |

## Verification
The assertions check several properties on every cycle. They check that each strobe coincides with a real level change of the card clock, and that the clock is forced low with quiet strobes one cycle after enable drops. They check that the active phase lengths differ by at most one and change only at a rising strobe, and that the hold-off flag clears after a start and rises only after a strobe. The exact phase lengths for each code and mode can only be shown by the bench's sweep, which counts cycles at the output. The same holds for the reset ratio, the end-of-range ratios, the deferral of a mid-phase write and the count of eight edges.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  localparam int CC_DIV_W   = 8;
  localparam int CC_LEN_W   = CC_DIV_W + 1;
  localparam int CC_REG_W   = 32;
  localparam int CC_ODD_BIT = 16;
  localparam int CC_LEG_BIT = 24;

  typedef struct packed {
    logic                legacy;
    logic                odd;
    logic [CC_DIV_W-1:0] div;
  } cc_mode_t;

  typedef logic [CC_LEN_W-1:0] cc_len_t;

  localparam cc_mode_t CC_MODE_RST = '{legacy: 1'b0, odd: 1'b1, div: '1};
endpackage

// File: rtl/card_clk_rst_sync.sv
module card_clk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/card_clk_mode_reg.sv
module card_clk_mode_reg
  import card_clk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CC_REG_W-1:0] wr_data,
  output cc_mode_t            mode_q
);
  cc_mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      mode_d.div    = wr_data[CC_DIV_W-1:0];
      mode_d.odd    = wr_data[CC_ODD_BIT];
      mode_d.legacy = wr_data[CC_LEG_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= CC_MODE_RST;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/card_clk_phase_calc.sv
module card_clk_phase_calc
  import card_clk_pkg::*;
#(
  parameter bit LEGACY_EN = 1'b1
) (
  input  cc_mode_t mode_i,
  output cc_len_t  hi_len_o,
  output cc_len_t  lo_len_o
);
  cc_len_t base_len;
  logic    leg_sel;

  assign base_len = cc_len_t'(mode_i.div) + cc_len_t'(1);

  generate
    if (LEGACY_EN) begin : g_legacy
      assign leg_sel = mode_i.legacy;
    end else begin : g_ext_only
      assign leg_sel = 1'b0;
    end
  endgenerate

  always_comb begin
    lo_len_o = base_len;
    if (leg_sel) hi_len_o = base_len;
    else         hi_len_o = base_len + cc_len_t'(mode_i.odd);
  end
endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
  import card_clk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  cc_len_t hi_len,
  input  cc_len_t lo_len,
  output logic    card_clk,
  output logic    rise_stb,
  output logic    fall_stb
);
  logic    clk_q, clk_d;
  logic    rise_q, rise_d;
  logic    fall_q, fall_d;
  logic    run_q, run_d;
  cc_len_t cnt_q, cnt_d;
  cc_len_t hi_q, hi_d;
  cc_len_t lo_q, lo_d;
  logic    start_hi, end_hi;

  assign start_hi = !run_q || (!clk_q && (cnt_q == lo_q));
  assign end_hi   = clk_q && (cnt_q == hi_q);

  always_comb begin
    clk_d  = clk_q;
    run_d  = run_q;
    cnt_d  = cnt_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (!enable) begin
      clk_d = 1'b0;
      run_d = 1'b0;
      cnt_d = '0;
    end else if (start_hi) begin
      clk_d  = 1'b1;
      rise_d = 1'b1;
      run_d  = 1'b1;
      cnt_d  = cc_len_t'(1);
      hi_d   = hi_len;
      lo_d   = lo_len;
    end else if (end_hi) begin
      clk_d  = 1'b0;
      fall_d = 1'b1;
      cnt_d  = cc_len_t'(1);
    end else begin
      cnt_d = cnt_q + cc_len_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      clk_q  <= clk_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign card_clk = clk_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;

  // R6
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!card_clk && !rise_stb && !fall_stb));
  // R7
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (card_clk && !$past(card_clk)));
  // R7
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!card_clk && $past(card_clk)));
  // R1
  phase_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ((hi_q == lo_q) || (hi_q == lo_q + cc_len_t'(1))));
  // R5
  cfg_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_stb |-> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/card_clk_holdoff.sv
module card_clk_holdoff #(
  parameter int HOLD_EDGES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rise_stb,
  output logic ready
);
  localparam int CW = $clog2(HOLD_EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_EDGES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;
  logic          cnt_en;

  assign cnt_en = !start && !rdy_q && rise_stb;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (start) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == LAST) rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;

  // R8
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
  // R8
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(rise_stb));
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int HOLD_EDGES = 8,
  parameter bit LEGACY_EN  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                mode_wr,
  input  logic [CC_REG_W-1:0] mode_wdata,
  input  logic                hold_start,
  output logic                card_clk,
  output logic                rise_stb,
  output logic                fall_stb,
  output logic                hold_ready
);
  logic     rst_n_i;
  cc_mode_t mode_q;
  cc_len_t  hi_len, lo_len;

  card_clk_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  card_clk_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n_i), .wr_en(mode_wr), .wr_data(mode_wdata),
    .mode_q(mode_q)
  );

  card_clk_phase_calc #(.LEGACY_EN(LEGACY_EN)) u_calc (
    .mode_i(mode_q), .hi_len_o(hi_len), .lo_len_o(lo_len)
  );

  card_clk_divider u_div (
    .clk(clk), .rst_n(rst_n_i), .enable(enable), .hi_len(hi_len),
    .lo_len(lo_len), .card_clk(card_clk), .rise_stb(rise_stb),
    .fall_stb(fall_stb)
  );

  card_clk_holdoff #(.HOLD_EDGES(HOLD_EDGES)) u_hold (
    .clk(clk), .rst_n(rst_n_i), .start(hold_start), .rise_stb(rise_stb),
    .ready(hold_ready)
  );
endmodule

// File: tb/test_card_clk_gen.sv
module test_card_clk_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        mode_wr;
  logic [31:0] mode_wdata;
  logic        hold_start;
  logic        card_clk, rise_stb, fall_stb, hold_ready;

  int checks = 0;
  int failures = 0;
  logic prev_clk = 1'b0;

  always #2 clk = ~clk;

  card_clk_gen i_card_clk_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .hold_start(hold_start), .card_clk(card_clk),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .hold_ready(hold_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one bus cycle; strobe relation checked against the sampled clock (R7, R6)
  task automatic step();
    bit en_b;
    bit er, ef;
    en_b = enable;
    @(negedge clk);
    er = en_b && card_clk && !prev_clk;
    ef = en_b && !card_clk && prev_clk;
    chk(rise_stb == er, "R7 rise strobe", int'(rise_stb), int'(er));
    chk(fall_stb == ef, "R7 fall strobe", int'(fall_stb), int'(ef));
    prev_clk = card_clk;
  endtask

  task automatic write_mode(input int div, input bit odd, input bit leg);
    mode_wdata = '0;
    mode_wdata[7:0] = 8'(div);
    mode_wdata[16]  = odd;
    mode_wdata[24]  = leg;
    mode_wr = 1'b1;
    step();
    mode_wr = 1'b0;
  endtask

  // call right after enable was raised from a stopped state
  task automatic measure(input int eh, input int el, input string req);
    int h = 0;
    int l = 0;
    step();
    chk(card_clk && rise_stb, {req, " fresh high"}, int'(card_clk), 1);
    while (card_clk && h < 2000) begin h++; step(); end
    while (!card_clk && l < 2000) begin l++; step(); end
    chk(h == eh, {req, " high cycles"}, h, eh);
    chk(l == el, {req, " low cycles"}, l, el);
  endtask

  task automatic run_cfg(input int div, input bit odd, input bit leg,
                         input int eh, input int el, input string req);
    enable = 1'b0;
    step();
    step();
    write_mode(div, odd, leg);
    enable = 1'b1;
    measure(eh, el, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    enable = 1'b0;
    mode_wr = 1'b0;
    mode_wdata = '0;
    hold_start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    // R4 reset state
    chk(!card_clk, "R4 clock low", int'(card_clk), 0);
    chk(!rise_stb && !fall_stb, "R4 strobes low", int'(rise_stb | fall_stb), 0);
    chk(hold_ready, "R4 ready", int'(hold_ready), 1);
    enable = 1'b1;
    measure(257, 256, "R4");

    // R1 / R2 sweep over small codes
    for (int d = 0; d < 6; d++) begin
      for (int o = 0; o < 2; o++) begin
        run_cfg(d, o[0], 1'b0, d + 1 + o, d + 1, "R1");
        run_cfg(d, o[0], 1'b1, d + 1, d + 1, "R2");
      end
    end

    // R3 range ends
    run_cfg(0, 1'b0, 1'b0, 1, 1, "R3 ext min");
    run_cfg(255, 1'b1, 1'b0, 257, 256, "R3 ext max");
    run_cfg(0, 1'b1, 1'b1, 1, 1, "R3 leg min");
    run_cfg(255, 1'b0, 1'b1, 256, 256, "R3 leg max");
    run_cfg(255, 1'b1, 1'b1, 256, 256, "R3 leg max odd");

    // R5 write mid high phase
    begin
      int h = 0;
      int l = 0;
      enable = 1'b0;
      step();
      write_mode(3, 1'b0, 1'b0);
      enable = 1'b1;
      step();
      h = 1;
      step();
      h = 2;
      write_mode(0, 1'b0, 1'b0);
      h = 3;
      while (card_clk && h < 100) begin h++; step(); end
      while (!card_clk && l < 100) begin l++; step(); end
      chk(h == 5, "R5 current high kept", h - 1, 4);
      chk(l == 4, "R5 current low kept", l, 4);
      h = 0;
      l = 0;
      while (card_clk && h < 100) begin h++; step(); end
      while (!card_clk && l < 100) begin l++; step(); end
      chk(h == 1, "R5 new high", h, 1);
      chk(l == 1, "R5 new low", l, 1);
    end

    // R6 disable while running, then restart
    enable = 1'b0;
    step();
    for (int i = 0; i < 10; i++) begin
      chk(!card_clk && !rise_stb && !fall_stb, "R6 held low",
          int'(card_clk | rise_stb | fall_stb), 0);
      step();
    end
    write_mode(2, 1'b1, 1'b0);
    enable = 1'b1;
    measure(4, 3, "R6 restart");

    // R8 hold-off of eight rising edges
    begin
      int n = 0;
      bit done = 1'b0;
      hold_start = 1'b1;
      for (int i = 0; i < 200 && !done; i++) begin
        step();
        hold_start = 1'b0;
        chk(!hold_ready, "R8 not ready early", int'(hold_ready), 0);
        if (rise_stb) begin
          n++;
          if (n == 8) begin
            step();
            chk(hold_ready, "R8 ready after 8th edge", int'(hold_ready), 1);
            done = 1'b1;
          end
        end
      end
      chk(n == 8, "R8 edge count", n, 8);
      repeat (20) step();
      chk(hold_ready, "R8 ready stays", int'(hold_ready), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule